// File: doc/BRIEF.md
# Coprocessor Transfer Address Sequencer

This block is the processor-side engine for a coprocessor load/store instruction. It takes a 32-bit instruction word of the coprocessor data-transfer class, a condition-pass flag worked out elsewhere, and the current value of the base register. From these it produces a stream of word addresses toward memory, together with the transfer direction. The coprocessor is the one that supplies or takes the data, and it also decides how many words are moved: the sequence ends in the cycle where the coprocessor raises its last-word input.

The block forwards the coprocessor number, the coprocessor register index and the length-select bit to the coprocessor while it is busy. It then waits for the coprocessor to accept the instruction. If no acceptance arrives within a fixed number of cycles, it raises an undefined-instruction flag and transfers nothing.

The instruction's 8-bit immediate is a word count, and the block scales it by four. Pre-indexing applies the offset before the first transfer. Post-indexing starts at the unmodified base. When write-back is requested, the block returns the base plus or minus the scaled offset on completion, together with the base register index.

Top module: `cpx_xfer_seq`

## Requirements
- R1: After a synchronous reset, busy, mem_req, done, wb_valid and undef are all 0.
- R2: A start is only taken when instruction bits [27:25] equal 3'b110. The fields are: P = bit 24, U = bit 23, N = bit 22, W = bit 21, L = bit 20, base index = [19:16], coprocessor register = [15:12], coprocessor number = [11:8], word offset = [7:0]. Any other class is ignored: busy stays 0, done stays 0 and no transfer occurs. cond_field always shows bits [31:28].
- R3: A start is accepted but cond_pass is 0. Then done is 1 in the following cycle, busy stays 0, and no memory access or write-back ever follows.
- R4: The first transfer address is computed as follows. With P=1 it is the base plus the offset times 4 (U=1) or minus the offset times 4 (U=0), modulo 2^32. With P=0 it is the unmodified base.
- R5: mem_req rises in the cycle after cp_accept is sampled during the wait. Each later word's address is 4 above the previous one. The word present while cp_last is 1 is the final one, and mem_req is 0 in the cycle after it.
- R6: mem_write equals the inverse of L throughout the transfer (L=1 is a load from memory, so mem_write=0).
- R7: With W=1, wb_valid pulses together with done after the final word. wb_value is then the base plus or minus the offset times 4 (per U), whatever the word count, and wb_reg is bits [19:16]. With W=0, wb_valid stays 0.
- R8: The block waits for acceptance. If cp_accept is not seen within TIMEOUT cycles, undef pulses for one cycle, the block returns to idle, and no memory access or write-back occurs. An accept in the TIMEOUT-th cycle is still honoured.
- R9: A start pulse while busy is 1 is ignored. The running sequence continues with its own addresses and fields.
- R10: While busy, cp_id, cp_reg and cp_long show the coprocessor number, the coprocessor register and the N bit of the accepted instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Instruction issue strobe |
| instr | input | 32 | Instruction word |
| cond_pass | input | 1 | Result of the external condition check |
| base_in | input | ADDR_W | Base register value |
| cp_accept | input | 1 | Coprocessor has claimed the instruction |
| cp_last | input | 1 | Coprocessor marks the current word as the final one |
| cond_field | output | 4 | Condition bits of instr, for the external evaluator |
| busy | output | 1 | Waiting for acceptance or transferring |
| cp_id | output | 4 | Coprocessor number of the accepted instruction |
| cp_reg | output | 4 | Coprocessor register index |
| cp_long | output | 1 | Transfer-length select bit |
| mem_req | output | 1 | Memory word access this cycle |
| mem_addr | output | ADDR_W | Word address of the access |
| mem_write | output | 1 | 1 = store to memory, 0 = load from memory |
| done | output | 1 | One-cycle completion pulse |
| wb_valid | output | 1 | Base write-back strobe |
| wb_reg | output | 4 | Base register index for write-back |
| wb_value | output | ADDR_W | New base value |
| undef | output | 1 | One-cycle pulse when no coprocessor accepted |

## Verification
Several properties are checked every cycle: the 4-byte address step, the end of the transfer one cycle after the last-word mark, the coprocessor fields holding steady while busy, a write-back appearing only right after a transfer, undef never occurring together with done or write-back, and a failed condition ending with no access at all. The remaining behaviour can only be shown by the bench's scenarios. That covers the actual value of the first address for each P/U combination, the scaled write-back value, the direction bit, the exact timeout cycle against an accept in the last allowed cycle, and rejection of a wrong instruction class or of a start issued during a transfer. For these, the bench compares port values with its own expected results.

// File: rtl/cpx_pkg.sv
package cpx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_XFER = 2'd2
  } cpx_state_e;

  typedef struct packed {
    logic       is_cp;
    logic       pre;
    logic       up;
    logic       longx;
    logic       wback;
    logic       load;
    logic [3:0] cond;
    logic [3:0] rn;
    logic [3:0] crd;
    logic [3:0] cpn;
    logic [7:0] off;
  } cpx_fields_t;

  localparam logic [2:0] CPX_CLASS = 3'b110;

endpackage

// File: rtl/cpx_decode.sv
module cpx_decode
  import cpx_pkg::*;
(
  input  logic [31:0] instr,
  output cpx_fields_t fld
);
  always_comb begin
    fld.cond  = instr[31:28];
    fld.is_cp = (instr[27:25] == CPX_CLASS);
    fld.pre   = instr[24];
    fld.up    = instr[23];
    fld.longx = instr[22];
    fld.wback = instr[21];
    fld.load  = instr[20];
    fld.rn    = instr[19:16];
    fld.crd   = instr[15:12];
    fld.cpn   = instr[11:8];
    fld.off   = instr[7:0];
  end
endmodule

// File: rtl/cpx_addr_gen.sv
module cpx_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 8
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  off_words,
  input  logic              pre,
  input  logic              up,
  output logic [ADDR_W-1:0] first_addr,
  output logic [ADDR_W-1:0] moved_base
);
  localparam int PAD_W = ADDR_W - OFF_W - 2;

  logic [ADDR_W-1:0] off_bytes;

  always_comb begin
    off_bytes  = {{PAD_W{1'b0}}, off_words, 2'b00};
    moved_base = up ? (base + off_bytes) : (base - off_bytes);
    first_addr = pre ? moved_base : base;
  end
endmodule

// File: rtl/cpx_seq.sv
module cpx_seq
  import cpx_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int TIMEOUT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              cond_pass,
  input  logic              is_cp,
  input  logic              f_load,
  input  logic              f_wback,
  input  logic              f_longx,
  input  logic [3:0]        f_rn,
  input  logic [3:0]        f_crd,
  input  logic [3:0]        f_cpn,
  input  logic [ADDR_W-1:0] first_addr,
  input  logic [ADDR_W-1:0] moved_base,
  input  logic              cp_accept,
  input  logic              cp_last,
  output logic              busy,
  output logic [3:0]        cp_id,
  output logic [3:0]        cp_reg,
  output logic              cp_long,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_write,
  output logic              done,
  output logic              wb_valid,
  output logic [3:0]        wb_reg,
  output logic [ADDR_W-1:0] wb_value,
  output logic              undef
);
  localparam int CNT_W = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [CNT_W-1:0] LIM = CNT_W'(TIMEOUT - 1);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  cpx_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] wbv_q;
  logic              load_q, wback_q, longx_q;
  logic [3:0]        rn_q, crd_q, cpn_q;
  logic              done_q, undef_q, wbvld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      addr_q  <= '0;
      wbv_q   <= '0;
      load_q  <= 1'b0;
      wback_q <= 1'b0;
      longx_q <= 1'b0;
      rn_q    <= '0;
      crd_q   <= '0;
      cpn_q   <= '0;
      done_q  <= 1'b0;
      undef_q <= 1'b0;
      wbvld_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      undef_q <= 1'b0;
      wbvld_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start && is_cp) begin
            addr_q  <= first_addr;
            wbv_q   <= moved_base;
            load_q  <= f_load;
            wback_q <= f_wback;
            longx_q <= f_longx;
            rn_q    <= f_rn;
            crd_q   <= f_crd;
            cpn_q   <= f_cpn;
            cnt     <= '0;
            if (cond_pass) state  <= ST_WAIT;
            else           done_q <= 1'b1;
          end
        end
        ST_WAIT: begin
          if (cp_accept) begin
            state <= ST_XFER;
          end else if (cnt == LIM) begin
            undef_q <= 1'b1;
            state   <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_XFER: begin
          if (cp_last) begin
            state   <= ST_IDLE;
            done_q  <= 1'b1;
            wbvld_q <= wback_q;
          end else begin
            addr_q <= addr_q + STEP;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign mem_req   = (state == ST_XFER);
  assign mem_addr  = addr_q;
  assign mem_write = ~load_q;
  assign cp_id     = cpn_q;
  assign cp_reg    = crd_q;
  assign cp_long   = longx_q;
  assign done      = done_q;
  assign undef     = undef_q;
  assign wb_valid  = wbvld_q;
  assign wb_reg    = rn_q;
  assign wb_value  = wbv_q;

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_XFER && !cp_last) |=> (state == ST_XFER && addr_q == $past(addr_q) + STEP));

  // R5
  last_end_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_XFER && cp_last) |=> (state == ST_IDLE && done_q));

  // R3
  cond_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && start && is_cp && !cond_pass) |=> (state == ST_IDLE && done_q && !wbvld_q));

  // R7
  wb_after_xfer_chk: assert property (@(posedge clk) disable iff (rst)
    wbvld_q |-> (done_q && $past(state == ST_XFER)));

  // R8
  undef_clean_chk: assert property (@(posedge clk) disable iff (rst)
    undef_q |-> (!done_q && !wbvld_q && state == ST_IDLE));

  // R10
  fields_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> $stable({cpn_q, crd_q, longx_q, load_q, rn_q}));

endmodule

// File: rtl/cpx_xfer_seq.sv
module cpx_xfer_seq
  import cpx_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int TIMEOUT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [31:0]       instr,
  input  logic              cond_pass,
  input  logic [ADDR_W-1:0] base_in,
  input  logic              cp_accept,
  input  logic              cp_last,
  output logic [3:0]        cond_field,
  output logic              busy,
  output logic [3:0]        cp_id,
  output logic [3:0]        cp_reg,
  output logic              cp_long,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_write,
  output logic              done,
  output logic              wb_valid,
  output logic [3:0]        wb_reg,
  output logic [ADDR_W-1:0] wb_value,
  output logic              undef
);
  cpx_fields_t       fld;
  logic [ADDR_W-1:0] first_addr;
  logic [ADDR_W-1:0] moved_base;

  cpx_decode u_dec (
    .instr (instr),
    .fld   (fld)
  );

  cpx_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(8)) u_agen (
    .base       (base_in),
    .off_words  (fld.off),
    .pre        (fld.pre),
    .up         (fld.up),
    .first_addr (first_addr),
    .moved_base (moved_base)
  );

  cpx_seq #(.ADDR_W(ADDR_W), .TIMEOUT(TIMEOUT)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .cond_pass  (cond_pass),
    .is_cp      (fld.is_cp),
    .f_load     (fld.load),
    .f_wback    (fld.wback),
    .f_longx    (fld.longx),
    .f_rn       (fld.rn),
    .f_crd      (fld.crd),
    .f_cpn      (fld.cpn),
    .first_addr (first_addr),
    .moved_base (moved_base),
    .cp_accept  (cp_accept),
    .cp_last    (cp_last),
    .busy       (busy),
    .cp_id      (cp_id),
    .cp_reg     (cp_reg),
    .cp_long    (cp_long),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_write  (mem_write),
    .done       (done),
    .wb_valid   (wb_valid),
    .wb_reg     (wb_reg),
    .wb_value   (wb_value),
    .undef      (undef)
  );

  assign cond_field = fld.cond;

endmodule

// File: tb/test_cpx_xfer_seq.sv
module test_cpx_xfer_seq;
  localparam int TIMEOUT = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] instr = '0;
  logic        cond_pass = 1'b0;
  logic [31:0] base_in = '0;
  logic        cp_accept = 1'b0;
  logic        cp_last = 1'b0;
  logic [3:0]  cond_field, cp_id, cp_reg, wb_reg;
  logic        busy, cp_long, mem_req, mem_write, done, wb_valid, undef;
  logic [31:0] mem_addr, wb_value;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  cpx_xfer_seq #(.ADDR_W(32), .TIMEOUT(TIMEOUT)) i_cpx_xfer_seq (
    .clk(clk), .rst(rst), .start(start), .instr(instr), .cond_pass(cond_pass),
    .base_in(base_in), .cp_accept(cp_accept), .cp_last(cp_last),
    .cond_field(cond_field), .busy(busy), .cp_id(cp_id), .cp_reg(cp_reg),
    .cp_long(cp_long), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_write(mem_write), .done(done), .wb_valid(wb_valid), .wb_reg(wb_reg),
    .wb_value(wb_value), .undef(undef)
  );

  function automatic logic [31:0] exp_moved(input logic [31:0] ins, input logic [31:0] b);
    logic [31:0] o;
    o = {22'd0, ins[7:0], 2'b00};
    return ins[23] ? b + o : b - o;
  endfunction

  function automatic logic [31:0] exp_first(input logic [31:0] ins, input logic [31:0] b);
    return ins[24] ? exp_moved(ins, b) : b;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] ins, input logic [31:0] b, input bit cp,
                     input int dly, input int nw);
    bit is_cp;
    logic [31:0] fa;
    is_cp = (ins[27:25] == 3'b110);
    fa = exp_first(ins, b);
    @(negedge clk);
    start = 1'b1; instr = ins; base_in = b; cond_pass = cp;
    chk(cond_field == ins[31:28], "R2 cond_field", {28'd0, cond_field}, {28'd0, ins[31:28]});
    @(negedge clk);
    start = 1'b0; instr = $urandom; base_in = $urandom; cond_pass = 1'b1;
    if (!is_cp) begin
      chk(busy == 1'b0 && done == 1'b0, "R2 class ignored", {30'd0, busy, done}, 32'd0);
      cp_accept = 1'b1;
      @(negedge clk);
      cp_accept = 1'b0;
      chk(mem_req == 1'b0 && busy == 1'b0, "R2 no access", {30'd0, mem_req, busy}, 32'd0);
      return;
    end
    if (!cp) begin
      chk(done == 1'b1 && busy == 1'b0, "R3 done no busy", {30'd0, done, busy}, 32'd2);
      cp_accept = 1'b1;
      @(negedge clk);
      chk(mem_req == 1'b0 && wb_valid == 1'b0, "R3 no access", {30'd0, mem_req, wb_valid}, 32'd0);
      @(negedge clk);
      cp_accept = 1'b0;
      chk(mem_req == 1'b0 && busy == 1'b0, "R3 still idle", {30'd0, mem_req, busy}, 32'd0);
      return;
    end
    chk(busy == 1'b1 && mem_req == 1'b0, "R8 waiting", {30'd0, busy, mem_req}, 32'd2);
    if (dly >= TIMEOUT) begin
      for (int k = 0; k < TIMEOUT - 1; k++) begin
        @(negedge clk);
        chk(undef == 1'b0 && mem_req == 1'b0, "R8 before limit", {30'd0, undef, mem_req}, 32'd0);
      end
      @(negedge clk);
      chk(undef == 1'b1, "R8 undef", {31'd0, undef}, 32'd1);
      chk(mem_req == 1'b0 && wb_valid == 1'b0 && busy == 1'b0 && done == 1'b0,
          "R8 no transfer", {28'd0, mem_req, wb_valid, busy, done}, 32'd0);
      @(negedge clk);
      chk(undef == 1'b0, "R8 one pulse", {31'd0, undef}, 32'd0);
      return;
    end
    for (int k = 0; k < dly; k++) @(negedge clk);
    cp_accept = 1'b1;
    @(negedge clk);
    cp_accept = 1'b0;
    chk(cp_id == ins[11:8] && cp_reg == ins[15:12] && cp_long == ins[22], "R10 fields",
        {23'd0, cp_long, cp_reg, cp_id}, {23'd0, ins[22], ins[15:12], ins[11:8]});
    chk(mem_addr == fa, "R4 first address", mem_addr, fa);
    for (int w = 0; w < nw; w++) begin
      chk(mem_req == 1'b1, "R5 req", {31'd0, mem_req}, 32'd1);
      chk(mem_addr == fa + 32'(4 * w), "R5 step", mem_addr, fa + 32'(4 * w));
      chk(mem_write == ~ins[20], "R6 dir", {31'd0, mem_write}, {31'd0, ~ins[20]});
      if (w == 0) begin
        start = 1'b1;
        instr = {4'hE, 3'b110, 5'b11111, 20'hFFFFF} ^ ins;
        instr[27:25] = 3'b110;
        base_in = ~b;
      end
      cp_last = (w == nw - 1);
      @(negedge clk);
      start = 1'b0;
      cp_last = 1'b0;
    end
    chk(mem_req == 1'b0 && done == 1'b1, "R5 end", {30'd0, mem_req, done}, 32'd1);
    chk(wb_valid == ins[21], "R7 wb strobe", {31'd0, wb_valid}, {31'd0, ins[21]});
    if (ins[21]) begin
      chk(wb_value == exp_moved(ins, b), "R7 wb value", wb_value, exp_moved(ins, b));
      chk(wb_reg == ins[19:16], "R7 wb reg", {28'd0, wb_reg}, {28'd0, ins[19:16]});
    end
    @(negedge clk);
    chk(busy == 1'b0 && mem_req == 1'b0, "R9 no second start", {30'd0, busy, mem_req}, 32'd0);
  endtask

  function automatic logic [31:0] mk(input bit p, input bit u, input bit n, input bit wb,
                                     input bit l, input logic [7:0] off);
    return {$urandom_range(15, 0) & 4'hF, 3'b110, p, u, n, wb, l,
            4'($urandom_range(15, 0)), 4'($urandom_range(15, 0)),
            4'($urandom_range(15, 0)), off};
  endfunction

  initial begin
    void'($urandom(32'd20240917));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(busy == 0 && mem_req == 0 && done == 0 && wb_valid == 0 && undef == 0,
        "R1 reset", {27'd0, busy, mem_req, done, wb_valid, undef}, 32'd0);
    // R4 corner cases: pre/post, up/down, wrap and maximum offset
    run(mk(1, 0, 0, 1, 1, 8'hFF), 32'h0000_0010, 1'b1, 0, 3);
    run(mk(1, 1, 1, 1, 0, 8'hFF), 32'hFFFF_FFF0, 1'b1, 2, 1);
    run(mk(0, 0, 0, 1, 1, 8'h05), 32'h0000_1000, 1'b1, 1, 4);
    run(mk(0, 1, 1, 0, 0, 8'h00), 32'h8000_0000, 1'b1, 0, 2);
    // R8 boundary: accept in the last allowed cycle, then one cycle too late
    run(mk(1, 1, 0, 1, 1, 8'h10), 32'h0000_4000, 1'b1, TIMEOUT - 1, 2);
    run(mk(1, 1, 0, 1, 1, 8'h10), 32'h0000_4000, 1'b1, TIMEOUT, 2);
    // R3 condition fails, R2 wrong class
    run(mk(1, 1, 0, 1, 0, 8'h04), 32'h0000_2000, 1'b0, 0, 1);
    run(32'hE520_1104, 32'h0000_3000, 1'b1, 0, 1);
    for (int i = 0; i < 80; i++) begin
      logic [31:0] ins;
      int d;
      ins = mk(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
               8'($urandom));
      if ($urandom_range(9, 0) == 0) ins[27:25] = 3'($urandom_range(5, 0));
      d = ($urandom_range(9, 0) == 0) ? TIMEOUT + 1 : $urandom_range(TIMEOUT - 1, 0);
      run(ins, $urandom, ($urandom_range(7, 0) != 0), d, $urandom_range(6, 1));
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule